// File: doc/BRIEF.md
# Transmit Phase-Compensation FIFO

This block moves 16-bit transmit words from the clock domain of an upstream source into the domain of a locally generated transmit clock. Its job is to absorb the fixed but unknown phase offset between the two clocks. Words enter on the write clock whenever `wr_en` is high. The read side drains one word per read clock while data is present. After every flush, the read side waits until half the storage has filled before it starts reading, which leaves equal margin against running full and running dry.

A write that arrives while the storage is full raises a sticky overflow flag. Recovery is a timed flush, and the source of the flush request depends on the mode. In hardware mode the request comes from a pin, which the system may tie to the overflow flag (optionally ORed with another reset) to make the FIFO recover by itself. In host mode the pin is ignored and a small control register supplies the request: one bit for a manual flush and one bit that lets overflow start a flush automatically. While a flush is in progress, the read side outputs zero words and holds its ready indication low. Writes are discarded during this time. Normal output resumes a fixed number of read cycles after the request is withdrawn.

Top module: `tx_phase_fifo`

## Requirements
- R1: While `rst_n` is low and right after its release, `rd_ready`, `rd_valid` and `overflow` are 0 and `rd_data` is zero. `rd_ready` rises on its own within 10 read cycles after release.
- R2: When there is no overflow and no flush, every accepted word appears on `rd_data` with `rd_valid` high, in write order, with none lost or repeated.
- R3: Whenever `rd_valid` is 0, `rd_data` is all zeros. `rd_valid` stays 0 for as long as a flush is in progress.
- R4: After a flush or reset, `rd_valid` stays 0 until at least 4 words (half of the 8-entry depth) have been written. Once reading has started, it continues while any word is stored.
- R5: A write attempt while all 8 entries are occupied sets `overflow` to 1. `overflow` stays 1 until a flush request is accepted, and acceptance clears it.
- R6: A flush request is accepted only if it is held for at least 2 consecutive read cycles. A 1-cycle pulse leaves `rd_ready` high. An accepted request drives `rd_ready` low.
- R7: After an accepted request is withdrawn, `rd_ready` returns high within 8 to 10 read cycles. All words stored before the flush are discarded.
- R8: With `host_mode` high, `flush_pin` has no effect. Setting bit 0 of the control register at address 0x03 requests a flush for as long as the bit stays 1.
- R9: With `host_mode` high and bit 1 of the control register set, an overflow starts a flush by itself. `overflow` then clears and `rd_ready` returns high without further action.
- R10: `reg_rdata` returns the two control bits at [1:0] when `reg_addr` is 0x03, and zero at every other address. A write takes effect on the read-clock edge where `reg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock from the upstream source |
| rclk | input | 1 | Local transmit read clock; also clocks the register interface |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write strobe, sampled on `wclk` |
| wr_data | input | 16 | Word to store |
| flush_pin | input | 1 | Active-high flush request used in hardware mode; inactive when low |
| host_mode | input | 1 | 1 selects the control register as the flush source; 0 selects the pin |
| reg_we | input | 1 | Control register write strobe, sampled on `rclk` |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rd_data | output | 16 | Output word; zero when not valid |
| rd_valid | output | 1 | `rd_data` carries a stored word this cycle |
| rd_ready | output | 1 | High when no flush is in progress |
| overflow | output | 1 | Sticky overflow status, in the read domain |

## Verification
The assertions assume that `host_mode` is static between flushes and that `flush_pin` is held long enough to pass through a two-stage synchronizer. They also assume that no write is issued in the short window where the write side is still leaving a flush. The stimulus follows these rules in three ways. It changes mode only while the FIFO is idle, and it drives the pin and the register on read-clock falling edges. It resumes writing only several cycles after `rd_ready` has returned. The random phase keeps the write rate below the read rate, so full-storage conditions arise only in the directed overflow cases.

// File: rtl/txpf_pkg.sv
package txpf_pkg;
  typedef enum logic [1:0] {
    FS_RUN   = 2'd0,
    FS_FLUSH = 2'd1,
    FS_DRAIN = 2'd2
  } flush_st_e;

  localparam logic [7:0] CTRL_ADDR   = 8'h03;
  localparam int         CTRL_MAN    = 0;
  localparam int         CTRL_AUTO   = 1;
endpackage

// File: rtl/txpf_sync.sv
module txpf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/txpf_wr.sv
module txpf_wr #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          flush,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word,
  output logic          ovf
);
  localparam int DEPTH = 1 << AW;

  logic [AW:0]   wbin_q, wbin_d, wgray_q, wgray_d;
  logic          ovf_q, ovf_d;
  logic          full, push;
  logic [DW-1:0] mem_q [DEPTH];

  assign full = (wgray_q == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign push = wr_en & ~full & ~flush;

  always_comb begin
    wbin_d  = flush ? '0 : wbin_q + {{AW{1'b0}}, push};
    wgray_d = wbin_d ^ (wbin_d >> 1);
    ovf_d   = flush ? 1'b0 : (ovf_q | (wr_en & full));
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem_q[wbin_q[AW-1:0]] <= wr_data;
  end

  assign rd_word = mem_q[rd_addr];
  assign wgray   = wgray_q;
  assign ovf     = ovf_q;

  // R5: overflow is sticky until the flush reaches the write side
  a_r5_ovf_sticky: assert property (@(posedge wclk) disable iff (!wrst_n)
    (ovf_q && !flush) |=> ovf_q);

  // R5: a write attempt on a full store raises the flag
  a_r5_ovf_on_full: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full && !flush) |=> ovf_q);

  // R2: a full store never advances the write pointer
  a_r2_no_push_full: assert property (@(posedge wclk) disable iff (!wrst_n)
    (full && !flush) |=> (wbin_q == $past(wbin_q)) || (wbin_q == '0));
endmodule

// File: rtl/txpf_rd.sv
module txpf_rd #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          flush,
  input  logic [AW:0]   wgray_s,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int          DEPTH = 1 << AW;
  localparam logic [AW:0] HALF  = (AW+1)'(DEPTH / 2);

  logic [AW:0]   rbin_q, rbin_d, rgray_q, wbin_s, level;
  logic          started_q, started_d, empty, pop;
  logic [DW-1:0] data_q, data_d;
  logic          valid_q;

  always_comb begin
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign empty = (rgray_q == wgray_s);
  assign level = wbin_s - rbin_q;
  assign pop   = ~flush & started_q & ~empty;

  always_comb begin
    started_d = flush ? 1'b0 : (started_q | (level >= HALF));
    rbin_d    = flush ? '0 : rbin_q + {{AW{1'b0}}, pop};
    data_d    = pop ? rd_word : '0;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q    <= '0;
      rgray_q   <= '0;
      started_q <= 1'b0;
      data_q    <= '0;
      valid_q   <= 1'b0;
    end else begin
      rbin_q    <= rbin_d;
      rgray_q   <= rbin_d ^ (rbin_d >> 1);
      started_q <= started_d;
      data_q    <= data_d;
      valid_q   <= pop;
    end
  end

  assign rgray    = rgray_q;
  assign rd_addr  = rbin_q[AW-1:0];
  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  // R3: no word leaves while a flush holds the read side
  a_r3_quiet_in_flush: assert property (@(posedge rclk) disable iff (!rrst_n)
    flush |=> !rd_valid);

  // R3: idle output is all zeros
  a_r3_zero_idle: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_valid |-> (rd_data == '0));
endmodule

// File: rtl/txpf_ctl.sv
module txpf_ctl
  import txpf_pkg::*;
#(
  parameter int DRAIN_CYC = 6
) (
  input  logic       rclk,
  input  logic       rrst_n,
  input  logic       flush_pin,
  input  logic       host_mode,
  input  logic       ovf_s,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       rflush,
  output logic       rd_ready
);
  localparam int CW = $clog2(DRAIN_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DRAIN_CYC - 1);

  flush_st_e     st_q, st_d;
  logic          hseen_q, hseen_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    ctrl_q, ctrl_d;
  logic          req_raw, req_s;

  assign req_raw = host_mode ? (ctrl_q[CTRL_MAN] | (ctrl_q[CTRL_AUTO] & ovf_s))
                             : flush_pin;

  txpf_sync #(.W(1)) u_req_sync (
    .clk(rclk), .rst_n(rrst_n), .d(req_raw), .q(req_s)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_we && reg_addr == CTRL_ADDR) ctrl_d = reg_wdata[1:0];
  end

  always_comb begin
    st_d    = st_q;
    hseen_d = 1'b0;
    cnt_d   = cnt_q;
    unique case (st_q)
      FS_RUN: begin
        hseen_d = req_s;
        if (req_s && hseen_q) st_d = FS_FLUSH;
      end
      FS_FLUSH: begin
        if (!req_s) begin
          st_d  = FS_DRAIN;
          cnt_d = '0;
        end
      end
      FS_DRAIN: begin
        if (req_s) st_d = FS_FLUSH;
        else if (cnt_q == CNT_LAST) st_d = FS_RUN;
        else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = FS_DRAIN;
    endcase
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      st_q    <= FS_DRAIN;
      hseen_q <= 1'b0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      st_q    <= st_d;
      hseen_q <= hseen_d;
      cnt_q   <= cnt_d;
      ctrl_q  <= ctrl_d;
    end
  end

  assign rflush    = (st_q != FS_RUN);
  assign rd_ready  = (st_q == FS_RUN);
  assign reg_rdata = (reg_addr == CTRL_ADDR) ? {6'b0, ctrl_q} : 8'h00;

  // R6: leaving normal operation needs two consecutive request samples
  a_r6_two_cycle_accept: assert property (@(posedge rclk) disable iff (!rrst_n)
    ($past(st_q) == FS_RUN && st_q == FS_FLUSH) |-> ($past(req_s) && $past(req_s, 2)));

  // R7: normal operation resumes only from the timed drain
  a_r7_resume_from_drain: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(rd_ready) |-> ($past(st_q) == FS_DRAIN && !$past(req_s)));
endmodule

// File: rtl/tx_phase_fifo.sv
module tx_phase_fifo #(
  parameter int DW        = 16,
  parameter int AW        = 3,
  parameter int DRAIN_CYC = 6
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          flush_pin,
  input  logic          host_mode,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_ready,
  output logic          overflow
);
  logic          wrst_n, rrst_n;
  logic          rflush, wflush, ovf_w, ovf_r;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_word;

  txpf_sync #(.W(1)) u_wrst (.clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  txpf_sync #(.W(1)) u_rrst (.clk(rclk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  txpf_sync #(.W(1))    u_flush_w (.clk(wclk), .rst_n(wrst_n), .d(rflush), .q(wflush));
  txpf_sync #(.W(1))    u_ovf_r   (.clk(rclk), .rst_n(rrst_n), .d(ovf_w),  .q(ovf_r));
  txpf_sync #(.W(AW+1)) u_wptr_r  (.clk(rclk), .rst_n(rrst_n), .d(wgray),  .q(wgray_s));
  txpf_sync #(.W(AW+1)) u_rptr_w  (.clk(wclk), .rst_n(wrst_n), .d(rgray),  .q(rgray_s));

  txpf_wr #(.DW(DW), .AW(AW)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .flush(wflush), .rgray_s(rgray_s), .wgray(wgray),
    .rd_addr(rd_addr), .rd_word(rd_word), .ovf(ovf_w)
  );

  txpf_rd #(.DW(DW), .AW(AW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .flush(rflush), .wgray_s(wgray_s),
    .rgray(rgray), .rd_addr(rd_addr), .rd_word(rd_word),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  txpf_ctl #(.DRAIN_CYC(DRAIN_CYC)) u_ctl (
    .rclk(rclk), .rrst_n(rrst_n), .flush_pin(flush_pin), .host_mode(host_mode),
    .ovf_s(ovf_r), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rflush(rflush), .rd_ready(rd_ready)
  );

  assign overflow = ovf_r;
endmodule

// File: tb/tx_phase_fifo_bench.sv
`timescale 1ns/1ps
module tx_phase_fifo_bench;
  logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, flush_pin = 1'b0, host_mode = 1'b0;
  logic [15:0] wr_data = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] rd_data;
  logic        rd_valid, rd_ready, overflow;

  int errors = 0, checks = 0;
  bit sb_en = 1'b0, saw_valid = 1'b0, done = 1'b0;
  logic [15:0] expq[$];
  int n_in = 0, n_out = 0;

  always #4   rclk = ~rclk;   // 125 MHz read clock
  always #3.5 wclk = ~wclk;   // faster write clock

  tx_phase_fifo u_tx_phase_fifo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .flush_pin(flush_pin), .host_mode(host_mode), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_window(input int n);
    return (n >= 8) && (n <= 10);
  endfunction

  // scoreboard capture on the write side
  always @(posedge wclk) if (sb_en && wr_en) begin
    expq.push_back(wr_data);
    n_in++;
  end

  // output monitor, sampled away from the read edge
  always @(negedge rclk) begin
    if (rd_valid) saw_valid = 1'b1;
    if (sb_en && rst_n) begin
      if (!rd_valid) chk(rd_data == 16'h0, "R3 idle data zero", rd_data, 0);
      else if (expq.size() == 0) chk(1'b0, "R2 unexpected word", rd_data, -1);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        n_out++;
        chk(rd_data == e, "R2 word order", rd_data, e);
      end
    end
  end

  task automatic wr_word(input logic [15:0] d);
    @(negedge wclk); wr_en = 1'b1; wr_data = d;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge rclk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge rclk); reg_we = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rd_ready && n < 40) begin
      @(posedge rclk); n++; @(negedge rclk);
    end
  endtask

  task automatic pin_hold(input int cycles);
    @(negedge rclk); flush_pin = 1'b1;
    repeat (cycles) @(negedge rclk);
    flush_pin = 1'b0;
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit stayed;
    void'($urandom(32'd1357));

    // R1 reset state
    repeat (5) @(negedge rclk);
    chk(!rd_ready && !rd_valid && !overflow && rd_data == 0, "R1 in reset",
        {rd_ready, rd_valid, overflow}, 0);
    @(negedge rclk); rst_n = 1'b1;
    @(negedge rclk);
    chk(!rd_ready && !overflow, "R1 after release", rd_ready, 0);
    wait_ready(n);
    chk(n <= 10 && rd_ready, "R1 ready after reset", n, 10);
    repeat (6) @(negedge rclk);

    // R4 prefill: three words are held back
    sb_en = 1'b1; saw_valid = 1'b0;
    wr_word(16'h1111); wr_word(16'h2222); wr_word(16'h3333);
    repeat (12) @(negedge rclk);
    chk(!saw_valid, "R4 no read below half", saw_valid, 0);
    wr_word(16'h4444);
    repeat (12) @(negedge rclk);
    chk(saw_valid && expq.size() == 0, "R4 read after half", expq.size(), 0);

    // R2 random traffic below the read rate
    repeat (400) begin
      @(negedge wclk);
      wr_en   = (($urandom % 5) < 2);
      wr_data = 16'($urandom);
    end
    @(negedge wclk); wr_en = 1'b0;
    repeat (30) @(negedge rclk);
    chk(expq.size() == 0 && n_in == n_out, "R2 all words delivered", n_out, n_in);

    // R6 one-cycle pulse is ignored
    pin_hold(1);
    stayed = 1'b1;
    repeat (15) begin @(negedge rclk); if (!rd_ready) stayed = 1'b0; end
    chk(stayed, "R6 short pulse ignored", stayed, 1);

    // R5 overflow under sustained writes
    sb_en = 1'b0;
    @(negedge wclk); wr_en = 1'b1;
    repeat (250) begin @(negedge wclk); wr_data = 16'($urandom); end
    wr_en = 1'b0;
    repeat (6) @(negedge rclk);
    chk(overflow, "R5 overflow raised", overflow, 1);
    repeat (20) @(negedge rclk);
    chk(overflow && rd_ready, "R5 overflow sticky", overflow, 1);

    // R6/R7 pin flush, timed return, discard
    pin_hold(5);
    chk(!rd_ready && !rd_valid, "R6 accepted flush drops ready", rd_ready, 0);
    wait_ready(n);
    chk(in_window(n), "R7 ready return window", n, 9);
    chk(!overflow, "R5 overflow cleared by flush", overflow, 0);
    saw_valid = 1'b0;
    repeat (12) @(negedge rclk);
    chk(!saw_valid, "R7 stored words discarded", saw_valid, 0);

    // R8 host mode ignores the pin, register bit 0 flushes
    @(negedge rclk); host_mode = 1'b1;
    repeat (4) @(negedge rclk);
    pin_hold(6);
    stayed = 1'b1;
    repeat (6) begin @(negedge rclk); if (!rd_ready) stayed = 1'b0; end
    chk(stayed, "R8 pin ignored in host mode", stayed, 1);
    reg_write(8'h03, 8'h01);
    repeat (5) @(negedge rclk);
    chk(!rd_ready, "R8 register flush", rd_ready, 0);
    reg_addr = 8'h03; #1;
    chk(reg_rdata == 8'h01, "R10 readback manual bit", reg_rdata, 1);
    reg_write(8'h03, 8'h00);
    wait_ready(n);
    chk(in_window(n), "R7 R8 register flush return", n, 8);

    // R10 decode
    reg_write(8'h03, 8'hFE);
    reg_addr = 8'h03; #1;
    chk(reg_rdata == 8'h02, "R10 only two bits kept", reg_rdata, 2);
    reg_addr = 8'h05; #1;
    chk(reg_rdata == 8'h00, "R10 other address zero", reg_rdata, 0);
    chk(rd_ready, "R10 auto bit alone no flush", rd_ready, 1);

    // R9 automatic flush on overflow
    n = 0;
    @(negedge wclk); wr_en = 1'b1;
    while (rd_ready && n < 600) begin @(negedge wclk); wr_data = 16'($urandom); n++; end
    wr_en = 1'b0;
    chk(!rd_ready, "R9 overflow starts flush", rd_ready, 0);
    wait_ready(n);
    chk(rd_ready && n < 40, "R9 ready returns by itself", n, 9);
    repeat (4) @(negedge rclk);
    chk(!overflow, "R9 overflow cleared", overflow, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule